// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

The block moves data between memory and I/O locations on behalf of two independent channels. Software sets each channel up through a write-only register port: a source pointer, a destination pointer, a 16-bit transfer count and a control word. Each channel then runs one of two ways. In unsynchronized mode it moves data as soon as it is armed. In synchronized mode each rising edge of its request input moves one unit of data. The request comes either from an external pin or from an internal peripheral strobe.

Every transfer uses the block's single bus. First comes a fetch cycle that reads the source. In the next cycle a deposit cycle writes the fetched data to the destination. At least one idle cycle follows before the next fetch can be issued. When both channels are ready at once, the static priority bits decide which goes first. If the two bits are equal, the channel that was not served most recently goes first. A transfer count that reaches zero can disarm the channel and raise a one-cycle completion interrupt. A halt input stops any new transfer from being granted.

Control word layout: bit 0 start, bit 1 start-write enable, bit 2 word size (1 = 16-bit, 0 = byte), bit 3 source in memory space (0 = I/O space), bit 4 source increment, bit 5 source decrement, bit 6 destination in memory space, bit 7 destination increment, bit 8 destination decrement, bit 9 stop at terminal count, bit 10 interrupt enable, bit 11 high priority, bit 12 internal request select (0 = external pin), bits 14:13 mode (0 = unsynchronized, any other value = synchronized). Register select: 0 control, 1 source pointer, 2 destination pointer, 3 transfer count.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset no fetch or deposit cycle occurs, both interrupt outputs are 0 and both channels are disarmed.
- R2: A transfer is a fetch cycle (bus_rd=1, bus_addr = source pointer) followed in the next cycle by a deposit cycle (bus_wr=1, bus_addr = destination pointer, bus_wdata = the data read in the fetch). There is at least one cycle with neither strobe before the next fetch, and exactly one when another transfer is already ready.
- R3: After each transfer, a pointer whose increment bit alone is set grows by the step, and one whose decrement bit alone is set shrinks by the step. A pointer with both bits set or neither set keeps its value. The step is 2 in word mode and 1 in byte mode, and bus_word shows the mode.
- R4: bus_io is 1 during a fetch whose source space bit is 0, and during a deposit whose destination space bit is 0. It is 0 otherwise.
- R5: A control write updates the start bit only if bit 1 of the same write is 1. Otherwise the start bit keeps its value while the other control fields are updated.
- R6: In unsynchronized mode an armed channel transfers with no request. It stops and disarms when its count reaches zero, whatever the value of its terminal-count bit.
- R7: In synchronized mode start only arms the channel. Each rising edge of the selected request gives exactly one transfer, and a request held high gives only one.
- R8: With bit 12 = 0 only ext_dreq is seen, and with bit 12 = 1 only int_dreq is seen. The other source has no effect.
- R9: The count drops by one per transfer in both byte and word mode. In synchronized mode, with the terminal-count bit set, the channel disarms as the count reaches zero. With the bit clear it keeps transferring.
- R10: irq[ch] pulses high for exactly one cycle, in the cycle after the deposit that disarmed the channel at terminal count. This happens only when both the interrupt-enable bit and the terminal-count bit are set.
- R11: When both channels are ready in the same idle cycle and their priority bits differ, the channel with its bit set is granted first.
- R12: When both channels are ready with equal priority bits, the channel not served most recently is granted first.
- R13: While halt_in is 1, no new fetch cycle starts. A transfer already under way completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel addressed by the write |
| reg_sel | input | 2 | Register select (0 control, 1 source, 2 destination, 3 count) |
| reg_wdata | input | ADDR_W | Register write data |
| ext_dreq | input | 2 | External request pins, one per channel |
| int_dreq | input | 2 | Internal peripheral request strobes, one per channel |
| halt_in | input | 1 | Blocks new grants while high |
| bus_rd | output | 1 | Fetch cycle strobe |
| bus_wr | output | 1 | Deposit cycle strobe |
| bus_io | output | 1 | Current cycle targets I/O space |
| bus_word | output | 1 | Current cycle is 16-bit wide |
| bus_addr | output | ADDR_W | Current cycle address |
| bus_wdata | output | DATA_W | Deposit data |
| bus_rdata | input | DATA_W | Fetch data, sampled at the end of the fetch cycle |
| irq | output | 2 | Completion interrupt pulses, one per channel |

## Verification
The hardest cases to reach are the round-robin tie-breaks, because the outcome depends on which channel was served most recently, and that history cannot be seen at the ports. The bench builds the history on purpose. It serves one channel alone with a single request, then raises both request pins in the same cycle, and reads the grant order from the address region of the first fetch. It then serves the other channel alone and repeats the pair. Finally it shows that a priority bit overrides the order the round-robin would have chosen.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FETCH   = 2'd1,
      ST_DEPOSIT = 2'd2
   } seq_state_e;

   // control fields above the start / start-write-enable bits, MSB first
   typedef struct packed {
      logic [1:0] mode;
      logic       req_int;
      logic       prio;
      logic       irq_en;
      logic       tc_stop;
      logic       dst_dec;
      logic       dst_inc;
      logic       dst_mem;
      logic       src_dec;
      logic       src_inc;
      logic       src_mem;
      logic       word;
   } chan_cfg_t;

   localparam int CFG_LSB   = 2;
   localparam int CFG_W     = $bits(chan_cfg_t);
   localparam int START_BIT = 0;
   localparam int CHG_BIT   = 1;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_SRC  = 2'd1;
   localparam logic [1:0] SEL_DST  = 2'd2;
   localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/dma2_ptr.sv
module dma2_ptr #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_en,
   input  logic              inc,
   input  logic              dec,
   input  logic              word,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W-1:0] stride;
   logic              moves;

   assign stride = {{(ADDR_W-2){1'b0}}, word, ~word};
   assign moves  = step_en & (inc ^ dec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= load_val;
      else if (moves)
         ptr <= inc ? (ptr + stride) : (ptr - stride);
   end
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              ext_req,
   input  logic              int_req,
   input  logic              grant,
   input  logic              done,
   output logic              ready,
   output chan_cfg_t         cfg,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic              irq
);
   localparam int NPTR = 2;

   logic             start_q;
   logic             pend_q;
   logic             req_prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             sel_req;
   logic             req_edge;
   logic             sync_mode;
   logic             hit_zero;
   logic             stop;
   logic             wr_ctrl;

   logic [ADDR_W-1:0] ptr_q   [NPTR];
   logic              p_load  [NPTR];
   logic              p_inc   [NPTR];
   logic              p_dec   [NPTR];

   assign wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
   assign sync_mode = (cfg.mode != 2'd0);
   assign sel_req   = cfg.req_int ? int_req : ext_req;
   assign req_edge  = sel_req & ~req_prev_q;
   assign cnt_next  = cnt_q - 1'b1;
   assign hit_zero  = done && (cnt_next == '0);
   assign stop      = hit_zero && (!sync_mode || cfg.tc_stop);
   assign ready     = start_q && (sync_mode ? pend_q : 1'b1);

   assign p_load[0] = wr_en && (wr_sel == SEL_SRC);
   assign p_load[1] = wr_en && (wr_sel == SEL_DST);
   assign p_inc[0]  = cfg.src_inc;
   assign p_dec[0]  = cfg.src_dec;
   assign p_inc[1]  = cfg.dst_inc;
   assign p_dec[1]  = cfg.dst_dec;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dma2_ptr #(.ADDR_W(ADDR_W)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (p_load[g]),
         .load_val(wr_data),
         .step_en (done),
         .inc     (p_inc[g]),
         .dec     (p_dec[g]),
         .word    (cfg.word),
         .ptr     (ptr_q[g])
      );
   end

   assign src_ptr = ptr_q[0];
   assign dst_ptr = ptr_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg        <= '0;
         start_q    <= 1'b0;
         pend_q     <= 1'b0;
         req_prev_q <= 1'b0;
         cnt_q      <= '0;
         irq        <= 1'b0;
      end else begin
         req_prev_q <= sel_req;
         pend_q     <= (pend_q & ~grant & start_q) | (req_edge & start_q);
         irq        <= stop & cfg.irq_en & cfg.tc_stop;
         if (wr_ctrl)
            cfg <= chan_cfg_t'(wr_data[CFG_LSB +: CFG_W]);
         if (wr_ctrl && wr_data[CHG_BIT])
            start_q <= wr_data[START_BIT];
         else if (stop)
            start_q <= 1'b0;
         if (wr_en && (wr_sel == SEL_CNT))
            cnt_q <= wr_data[CNT_W-1:0];
         else if (done)
            cnt_q <= cnt_next;
      end
   end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] ready,
   input  logic [1:0] prio,
   output logic       gnt_valid,
   output logic       gnt_ch
);
   logic last_q;
   logic pick;

   always_comb begin
      if (ready[0] && ready[1])
         pick = (prio[0] != prio[1]) ? prio[1] : ~last_q;
      else
         pick = ready[1];
   end

   assign gnt_valid = en && (|ready);
   assign gnt_ch    = pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_q <= 1'b0;
      else if (gnt_valid)
         last_q <= pick;
   end
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
   import dma2_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gnt_valid,
   input  logic              gnt_ch,
   input  logic [DATA_W-1:0] rdata,
   output seq_state_e        state,
   output logic              cur_ch,
   output logic [DATA_W-1:0] data_q,
   output logic [1:0]        grant,
   output logic [1:0]        done
);
   for (genvar g = 0; g < 2; g++) begin : g_str
      assign grant[g] = gnt_valid && (gnt_ch == g[0]);
      assign done[g]  = (state == ST_DEPOSIT) && (cur_ch == g[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cur_ch <= 1'b0;
         data_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (gnt_valid) begin
               state  <= ST_FETCH;
               cur_ch <= gnt_ch;
            end
            ST_FETCH: begin
               data_q <= rdata;
               state  <= ST_DEPOSIT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
   import dma2_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_ch,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic [1:0]        ext_dreq,
   input  logic [1:0]        int_dreq,
   input  logic              halt_in,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_io,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        irq
);
   localparam int NCH = 2;

   if (ADDR_W < CFG_LSB + CFG_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the control word");
   end
   if (ADDR_W < CNT_W) begin : g_bad_cnt
      $error("ADDR_W must hold the transfer count");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("DATA_W must be 16 for byte/word transfers");
   end

   chan_cfg_t         cfg     [NCH];
   logic [ADDR_W-1:0] src_ptr [NCH];
   logic [ADDR_W-1:0] dst_ptr [NCH];
   logic [NCH-1:0]    ready;
   logic [NCH-1:0]    prio;
   logic [NCH-1:0]    grant;
   logic [NCH-1:0]    done;
   logic              gnt_valid;
   logic              gnt_ch;
   logic              cur_ch;
   logic [DATA_W-1:0] data_q;
   seq_state_e        state;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && (reg_ch == c[0])),
         .wr_sel  (reg_sel),
         .wr_data (reg_wdata),
         .ext_req (ext_dreq[c]),
         .int_req (int_dreq[c]),
         .grant   (grant[c]),
         .done    (done[c]),
         .ready   (ready[c]),
         .cfg     (cfg[c]),
         .src_ptr (src_ptr[c]),
         .dst_ptr (dst_ptr[c]),
         .irq     (irq[c])
      );
      assign prio[c] = cfg[c].prio;
   end

   dma2_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       ((state == ST_IDLE) && !halt_in),
      .ready    (ready),
      .prio     (prio),
      .gnt_valid(gnt_valid),
      .gnt_ch   (gnt_ch)
   );

   dma2_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_valid(gnt_valid),
      .gnt_ch   (gnt_ch),
      .rdata    (bus_rdata),
      .state    (state),
      .cur_ch   (cur_ch),
      .data_q   (data_q),
      .grant    (grant),
      .done     (done)
   );

   always_comb begin
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      bus_io    = 1'b0;
      bus_word  = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      if (state == ST_FETCH) begin
         bus_rd   = 1'b1;
         bus_io   = ~cfg[cur_ch].src_mem;
         bus_word = cfg[cur_ch].word;
         bus_addr = src_ptr[cur_ch];
      end else if (state == ST_DEPOSIT) begin
         bus_wr    = 1'b1;
         bus_io    = ~cfg[cur_ch].dst_mem;
         bus_word  = cfg[cur_ch].word;
         bus_addr  = dst_ptr[cur_ch];
         bus_wdata = data_q;
      end
   end
endmodule

// File: rtl/dma2_ctrl_chk.sv
module dma2_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rd,
   input logic       bus_wr,
   input logic       halt_in,
   input logic [1:0] irq
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));                                        // R2
   AST_DEPOSIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_wr);                                          // R2
   AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_rd);                                         // R2
   AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_in && !bus_rd && !bus_wr) |=> !bus_rd);                // R13
   AST_IRQ0_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[0] |=> !irq[0]);                                         // R10
   AST_IRQ1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[1] |=> !irq[1]);                                         // R10
   AST_IRQ_AFTER_DEPOSIT: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |-> $past(bus_wr));                                   // R10
endmodule

bind dma2_ctrl dma2_ctrl_chk u_chk (.*);

// File: tb/dma2_ctrl_test.sv
module dma2_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int LOGN = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic          reg_ch = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic [1:0]    ext_dreq = '0;
   logic [1:0]    int_dreq = '0;
   logic          halt_in = 1'b0;
   logic          bus_rd, bus_wr, bus_io, bus_word;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata, bus_rdata;
   logic [1:0]    irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign bus_rdata = bus_addr[15:0] ^ 16'hA55A;

   dma2_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ext_dreq(ext_dreq),
      .int_dreq(int_dreq), .halt_in(halt_in), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_io(bus_io), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // bus monitor
   logic [AW-1:0] fa [LOGN];
   logic [AW-1:0] da [LOGN];
   logic          fio [LOGN];
   logic          dio [LOGN];
   logic          fwd [LOGN];
   logic [15:0]   dwd [LOGN];
   int            fcyc [LOGN];
   int            dcyc [LOGN];
   int nf = 0, nd = 0, cyc = 0;
   int irq_cnt0 = 0, irq_cnt1 = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (bus_rd && nf < LOGN) begin
         fa[nf] = bus_addr; fio[nf] = bus_io; fwd[nf] = bus_word;
         fcyc[nf] = cyc; nf = nf + 1;
      end
      if (bus_wr && nd < LOGN) begin
         da[nd] = bus_addr; dio[nd] = bus_io; dwd[nd] = bus_wdata;
         dcyc[nd] = cyc; nd = nd + 1;
      end
      if (irq[0]) irq_cnt0 = irq_cnt0 + 1;
      if (irq[1]) irq_cnt1 = irq_cnt1 + 1;
   end

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_log();
      nf = 0; nd = 0; irq_cnt0 = 0; irq_cnt1 = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic ch, input logic [1:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [AW-1:0] mk(
      input bit start, chg, word, smem, sinc, sdec, dmem, dinc, ddec,
      input bit tc, ie, pr, rint, input logic [1:0] mode);
      logic [AW-1:0] v = '0;
      v[0] = start; v[1] = chg; v[2] = word; v[3] = smem; v[4] = sinc;
      v[5] = sdec; v[6] = dmem; v[7] = dinc; v[8] = ddec; v[9] = tc;
      v[10] = ie; v[11] = pr; v[12] = rint; v[14:13] = mode;
      return v;
   endfunction

   task automatic pulse_ext(input logic [1:0] m);
      @(negedge clk); ext_dreq = m;
      @(negedge clk); ext_dreq = 2'b00;
      idle(10);
   endtask

   task automatic pulse_int(input logic [1:0] m);
      @(negedge clk); int_dreq = m;
      @(negedge clk); int_dreq = 2'b00;
      idle(10);
   endtask

   task automatic t_reset();
      idle(5);
      check(nf == 0 && nd == 0, "R1 no bus cycle after reset", nf + nd, 0);
      check(irq == 2'b00, "R1 irq idle after reset", irq, 0);
      check(bus_rd == 0 && bus_wr == 0, "R1 strobes low", {bus_rd, bus_wr}, 0);
   endtask

   task automatic t_unsync_byte();
      clear_log();
      wr(0, 2'd1, 20'h01000);
      wr(0, 2'd2, 20'h03000);
      wr(0, 2'd3, 20'd3);
      wr(0, 2'd0, mk(1,1,0, 1,1,0, 1,1,0, 1,1,0,0, 2'd0));
      idle(30);
      check(nf == 3 && nd == 3, "R6 unsync runs to zero", nd, 3);
      for (int i = 0; i < 3; i++) begin
         check(fa[i] == 20'h01000 + i, "R3 byte src increment", fa[i], 20'h01000 + i);
         check(da[i] == 20'h03000 + i, "R3 byte dst increment", da[i], 20'h03000 + i);
         check(dwd[i] == (fa[i][15:0] ^ 16'hA55A), "R2 deposit carries fetched data",
               dwd[i], fa[i][15:0] ^ 16'hA55A);
         check(dcyc[i] == fcyc[i] + 1, "R2 deposit next cycle", dcyc[i], fcyc[i] + 1);
         check(fio[i] == 0 && dio[i] == 0 && fwd[i] == 0, "R4 memory space byte",
               {fio[i], dio[i], fwd[i]}, 0);
      end
      check(fcyc[1] == dcyc[0] + 2, "R2 one idle cycle gap", fcyc[1], dcyc[0] + 2);
      check(irq_cnt0 == 1, "R10 one irq at terminal count", irq_cnt0, 1);
   endtask

   task automatic t_word_dec();
      clear_log();
      wr(1, 2'd1, 20'h02010);
      wr(1, 2'd2, 20'h04000);
      wr(1, 2'd3, 20'd2);
      wr(1, 2'd0, mk(1,1,1, 0,0,1, 1,1,1, 0,1,0,0, 2'd0));
      idle(30);
      check(nd == 2, "R6 unsync stops at zero with tc bit clear", nd, 2);
      check(fa[0] == 20'h02010 && fa[1] == 20'h0200E, "R3 word src decrement by 2",
            fa[1], 20'h0200E);
      check(da[0] == 20'h04000 && da[1] == 20'h04000, "R3 inc+dec holds dst", da[1], 20'h04000);
      check(fio[0] == 1 && dio[0] == 0, "R4 io source, memory dest", {fio[0], dio[0]}, 2'b10);
      check(fwd[0] == 1, "R3 bus_word in word mode", fwd[0], 1);
      check(irq_cnt1 == 0, "R10 no irq without tc bit", irq_cnt1, 0);
   endtask

   task automatic t_chg_start();
      clear_log();
      wr(0, 2'd1, 20'h01100);
      wr(0, 2'd2, 20'h03100);
      wr(0, 2'd3, 20'd2);
      wr(0, 2'd0, mk(1,0,0, 1,0,0, 1,0,0, 1,0,0,0, 2'd0));
      idle(20);
      check(nf == 0, "R5 start ignored without enable bit", nf, 0);
      wr(0, 2'd0, mk(1,1,0, 1,0,0, 1,0,0, 1,0,0,0, 2'd0));
      idle(20);
      check(nd == 2, "R5 start taken with enable bit", nd, 2);
      check(fa[1] == 20'h01100 && da[1] == 20'h03100, "R3 neither bit holds pointers",
            fa[1], 20'h01100);
   endtask

   task automatic t_sync();
      clear_log();
      wr(0, 2'd1, 20'h01200);
      wr(0, 2'd2, 20'h03200);
      wr(0, 2'd3, 20'd5);
      wr(0, 2'd0, mk(1,1,0, 1,1,0, 1,1,0, 1,1,0,0, 2'd1));
      idle(10);
      check(nf == 0, "R7 sync start only arms", nf, 0);
      pulse_int(2'b01);
      check(nf == 0, "R8 internal strobe ignored when external selected", nf, 0);
      pulse_ext(2'b01);
      check(nd == 1, "R7 one request one transfer", nd, 1);
      wr(0, 2'd0, mk(0,0,0, 1,1,0, 1,1,0, 1,1,0,0, 2'd1));
      pulse_ext(2'b01);
      check(nd == 2, "R5 rewrite without enable keeps channel armed", nd, 2);
      @(negedge clk); ext_dreq = 2'b01;
      idle(12);
      @(negedge clk); ext_dreq = 2'b00;
      idle(4);
      check(nd == 3, "R7 held request gives one transfer", nd, 3);
      wr(0, 2'd0, mk(0,0,0, 1,1,0, 1,1,0, 1,1,0,1, 2'd1));
      pulse_ext(2'b01);
      check(nd == 3, "R8 external pin ignored when internal selected", nd, 3);
      pulse_int(2'b01);
      check(nd == 4 && irq_cnt0 == 0, "R9 count not yet zero", nd, 4);
      pulse_int(2'b01);
      check(nd == 5 && irq_cnt0 == 1, "R10 irq when count reaches zero", irq_cnt0, 1);
      pulse_int(2'b01);
      check(nd == 5, "R9 channel disarmed at terminal count", nd, 5);
   endtask

   task automatic t_sync_notc();
      clear_log();
      wr(1, 2'd1, 20'h02300);
      wr(1, 2'd2, 20'h04300);
      wr(1, 2'd3, 20'd1);
      wr(1, 2'd0, mk(1,1,1, 1,1,0, 1,1,0, 0,1,0,0, 2'd2));
      pulse_ext(2'b10);
      pulse_ext(2'b10);
      pulse_ext(2'b10);
      check(nd == 3, "R9 keeps running past zero with tc bit clear", nd, 3);
      check(irq_cnt1 == 0, "R10 no irq with tc bit clear", irq_cnt1, 0);
      check(fa[2] == 20'h02304, "R9 count independent of word step", fa[2], 20'h02304);
      wr(1, 2'd0, mk(0,1,0, 1,0,0, 1,0,0, 0,0,0,0, 2'd2));
   endtask

   task automatic t_prio();
      clear_log();
      wr(0, 2'd1, 20'h01400); wr(0, 2'd2, 20'h03400); wr(0, 2'd3, 20'd20);
      wr(1, 2'd1, 20'h02400); wr(1, 2'd2, 20'h04400); wr(1, 2'd3, 20'd20);
      wr(0, 2'd0, mk(1,1,0, 1,1,0, 1,1,0, 1,0,1,0, 2'd1));
      wr(1, 2'd0, mk(1,1,0, 1,1,0, 1,1,0, 1,0,0,0, 2'd1));
      pulse_ext(2'b11);
      check(nd == 2 && fa[0][15:12] == 4'h1, "R11 priority channel 0 first", fa[0][15:12], 1);
      pulse_ext(2'b11);
      check(fa[2][15:12] == 4'h1, "R11 priority channel 0 first again", fa[2][15:12], 1);
      wr(0, 2'd0, mk(0,0,0, 1,1,0, 1,1,0, 1,0,0,0, 2'd1));
      pulse_ext(2'b01);
      pulse_ext(2'b11);
      check(nd == 7 && fa[5][15:12] == 4'h2, "R12 tie goes to channel 1 after channel 0",
            fa[5][15:12], 2);
      pulse_ext(2'b10);
      pulse_ext(2'b11);
      check(nd == 10 && fa[8][15:12] == 4'h1, "R12 tie goes to channel 0 after channel 1",
            fa[8][15:12], 1);
      wr(1, 2'd0, mk(0,0,0, 1,1,0, 1,1,0, 1,0,1,0, 2'd1));
      pulse_ext(2'b11);
      check(nd == 12 && fa[10][15:12] == 4'h2, "R11 priority beats rotation",
            fa[10][15:12], 2);
      wr(0, 2'd0, mk(0,1,0, 1,0,0, 1,0,0, 0,0,0,0, 2'd1));
      wr(1, 2'd0, mk(0,1,0, 1,0,0, 1,0,0, 0,0,0,0, 2'd1));
   endtask

   task automatic t_halt();
      clear_log();
      @(negedge clk); halt_in = 1'b1;
      wr(0, 2'd1, 20'h01500);
      wr(0, 2'd2, 20'h03500);
      wr(0, 2'd3, 20'd2);
      wr(0, 2'd0, mk(1,1,0, 1,1,0, 1,1,0, 1,0,0,0, 2'd0));
      idle(20);
      check(nf == 0, "R13 no fetch while halted", nf, 0);
      @(negedge clk); halt_in = 1'b0;
      idle(20);
      check(nd == 2, "R13 transfers resume after halt", nd, 2);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_unsync_byte();
      t_word_dec();
      t_chg_start();
      t_sync();
      t_sync_notc();
      t_prio();
      t_halt();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule